// File: doc/BRIEF.md
# RTC Tick and Alarm Interrupt Unit

This block produces the two interrupt sources of a real-time clock: a periodic tick and an alarm match. A 15-bit divider counts pulses of a 32.768 kHz clock enable. A 3-bit code picks a tick rate from one tick per second up to 128 ticks per second. A comparator watches the live time and date words against the alarm time and date words and reports the cycle in which the two first agree.

Each source has a sticky flag. A flag sets only while its enable is high. Software clears a flag by writing a 1 to its bit. The interrupt request is the OR of each flag gated by its enable. A one-cycle wakeup pulse is raised on a tick when the wakeup enable is on, and on every alarm flag set event. The timekeeping counter itself, register protection and power control are outside the block.

Top module: `rtc_tick_alarm_irq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `alarm_flag`, `tick_flag`, `irq` and `wake_req` are 0.
- R2: With rate code n on `tick_sel`, a tick occurs on every (32768 >> n)-th enabled cycle of a free-running 15-bit divider. After reset the first tick is on enabled cycle 32768 >> n. Code 0 gives 1 s and code 7 gives 1/128 s.
- R3: `tick_flag` becomes 1 on the clock edge of a tick when `tick_ie` is 1. It stays 0 on ticks while `tick_ie` is 0.
- R4: `alarm_flag` becomes 1 when `alarm_ie` is 1 and both `live_time == alarm_time` and `live_date == alarm_date` hold. A match of only the time or only the date does not set it.
- R5: The alarm flag sets only on the first cycle of a match. It does not set again while the match persists, including after software clears it. A match that begins while `alarm_ie` is 0 does not set the flag later.
- R6: A write (`flag_wr` = 1) clears `alarm_flag` when `flag_wdata` bit 0 is 1, and clears `tick_flag` when bit 1 is 1. A 0 in a bit leaves that flag unchanged.
- R7: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up 1.
- R8: `irq` = (`alarm_flag` AND `alarm_ie`) OR (`tick_flag` AND `tick_ie`), following the current enables combinationally.
- R9: `wake_req` pulses high for exactly one cycle after a tick while `wake_en` is 1. A tick with `wake_en` at 0 gives no pulse. This holds regardless of `tick_ie`.
- R10: An alarm flag set event also pulses `wake_req` for one cycle, whatever the value of `wake_en`.
- R11: Cycles with `clk32k_en` low do not advance the divider. A tick is counted only in enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk32k_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| tick_sel | input | 3 | Tick rate code, period 1 s >> code |
| tick_ie | input | 1 | Tick interrupt enable |
| alarm_ie | input | 1 | Alarm interrupt enable |
| wake_en | input | 1 | Tick wakeup enable |
| live_time | input | TIME_W (22) | Current time word |
| live_date | input | DATE_W (24) | Current date word |
| alarm_time | input | TIME_W (22) | Alarm time word |
| alarm_date | input | DATE_W (24) | Alarm date word |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Write-1-to-clear data: bit 0 alarm, bit 1 tick |
| alarm_flag | output | 1 | Sticky alarm flag |
| tick_flag | output | 1 | Sticky tick flag |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | One-cycle wakeup request |

## Verification
The hardest state to reach from the ports is a clear of the alarm flag while the match still holds. A second case is a match that begins with the enable off and is then kept up while the enable turns on. In both cases the flag must stay 0, because only a fresh match edge may set it. The stimulus table holds the live words equal to the alarm words across several rows and changes the enable and write fields under them. The one-second tick needs 32768 enabled cycles, so the bench holds the clock enable high and counts edges. It samples just before and just after the terminal edge. A second run, at a faster code, idles the enable in the middle of the count to show that idle cycles are not counted.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    // Bit positions inside the write-1-to-clear data word.
    localparam int ALARM_BIT = 0;
    localparam int TICK_BIT  = 1;
    localparam int FLAG_N    = 2;

    typedef struct packed {
        logic alarm;
        logic tick;
        logic wake;
    } flag_state_t;

    typedef struct packed {
        logic match;
    } cmp_state_t;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int DIV_W = 15,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_o
);
    localparam int NCODE = 2 ** SEL_W;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [NCODE-1:0] hit;

    // Code g ends its period when the low DIV_W-g count bits are all ones.
    generate
        for (genvar g = 0; g < NCODE; g++) begin : g_code
            if (g < DIV_W) begin : g_ok
                assign hit[g] = &st_q.cnt[DIV_W-1-g:0];
            end else begin : g_min
                assign hit[g] = 1'b1;
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.cnt = st_q.cnt + {{(DIV_W-1){1'b0}}, 1'b1};
        end
        tick_o = en & hit[sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_div_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> st_q.cnt == DIV_W'($past(st_q.cnt) + 1));
    p_div_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.cnt));
    p_tick_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> en);
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_irq_pkg::*;
#(
    parameter int TIME_W = 22,
    parameter int DATE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] live_time,
    input  logic [DATE_W-1:0] live_date,
    input  logic [TIME_W-1:0] alarm_time,
    input  logic [DATE_W-1:0] alarm_date,
    output logic              rise_o
);
    cmp_state_t st_d, st_q;
    logic time_eq, date_eq;

    always_comb begin
        time_eq    = (live_time == alarm_time);
        date_eq    = (live_date == alarm_date);
        st_d.match = time_eq & date_eq;
        rise_o     = st_d.match & ~st_q.match;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    p_rise_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (live_time == alarm_time) && (live_date == alarm_date));
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_evt,
    input  logic              alarm_rise,
    input  logic              tick_ie,
    input  logic              alarm_ie,
    input  logic              wake_en,
    input  logic              flag_wr,
    input  logic [FLAG_N-1:0] flag_wdata,
    output logic              alarm_flag_o,
    output logic              tick_flag_o,
    output logic              irq_o,
    output logic              wake_req_o
);
    flag_state_t st_d, st_q;
    logic set_tick, set_alarm, clr_tick, clr_alarm;

    always_comb begin
        set_tick  = tick_evt & tick_ie;
        set_alarm = alarm_rise & alarm_ie;
        clr_tick  = flag_wr & flag_wdata[TICK_BIT];
        clr_alarm = flag_wr & flag_wdata[ALARM_BIT];

        st_d = st_q;
        // A set in the same cycle overrides the clear.
        if (set_tick) begin
            st_d.tick = 1'b1;
        end else if (clr_tick) begin
            st_d.tick = 1'b0;
        end
        if (set_alarm) begin
            st_d.alarm = 1'b1;
        end else if (clr_alarm) begin
            st_d.alarm = 1'b0;
        end
        st_d.wake = (tick_evt & wake_en) | set_alarm;

        alarm_flag_o = st_q.alarm;
        tick_flag_o  = st_q.tick;
        wake_req_o   = st_q.wake;
        irq_o        = (st_q.alarm & alarm_ie) | (st_q.tick & tick_ie);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_tick_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_evt && tick_ie) |=> tick_flag_o);
    p_alarm_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_rise && alarm_ie) |=> alarm_flag_o);
    p_tick_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && flag_wdata[TICK_BIT] && !(tick_evt && tick_ie)) |=> !tick_flag_o);
    p_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_flag_o && !(flag_wr && flag_wdata[TICK_BIT])) |=> tick_flag_o);
    p_alarm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag_o && !(flag_wr && flag_wdata[ALARM_BIT])) |=> alarm_flag_o);
    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (alarm_flag_o || tick_flag_o));
    p_wake_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_evt && wake_en) |=> wake_req_o);
    p_wake_alarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_rise && alarm_ie) |=> wake_req_o);
    p_wake_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req_o && !tick_evt && !alarm_rise) |=> !wake_req_o);
endmodule

// File: rtl/rtc_tick_alarm_irq.sv
module rtc_tick_alarm_irq
    import rtc_irq_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int SEL_W  = 3,
    parameter int TIME_W = 22,
    parameter int DATE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk32k_en,
    input  logic [SEL_W-1:0]  tick_sel,
    input  logic              tick_ie,
    input  logic              alarm_ie,
    input  logic              wake_en,
    input  logic [TIME_W-1:0] live_time,
    input  logic [DATE_W-1:0] live_date,
    input  logic [TIME_W-1:0] alarm_time,
    input  logic [DATE_W-1:0] alarm_date,
    input  logic              flag_wr,
    input  logic [FLAG_N-1:0] flag_wdata,
    output logic              alarm_flag,
    output logic              tick_flag,
    output logic              irq,
    output logic              wake_req
);
    logic tick_evt;
    logic alarm_rise;

    rtc_tick_div #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (clk32k_en),
        .sel    (tick_sel),
        .tick_o (tick_evt)
    );

    rtc_alarm_cmp #(.TIME_W(TIME_W), .DATE_W(DATE_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .live_time  (live_time),
        .live_date  (live_date),
        .alarm_time (alarm_time),
        .alarm_date (alarm_date),
        .rise_o     (alarm_rise)
    );

    rtc_irq_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_evt     (tick_evt),
        .alarm_rise   (alarm_rise),
        .tick_ie      (tick_ie),
        .alarm_ie     (alarm_ie),
        .wake_en      (wake_en),
        .flag_wr      (flag_wr),
        .flag_wdata   (flag_wdata),
        .alarm_flag_o (alarm_flag),
        .tick_flag_o  (tick_flag),
        .irq_o        (irq),
        .wake_req_o   (wake_req)
    );
endmodule

// File: tb/rtc_tick_alarm_irq_tb.sv
module rtc_tick_alarm_irq_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [21:0] A_TIME = 22'h123456;
    localparam logic [23:0] A_DATE = 24'h240229;
    localparam logic [21:0] X_TIME = 22'h123457;
    localparam logic [23:0] X_DATE = 24'h240228;
    // {time_eq, date_eq, alarm_ie, wr, wdata[1:0], exp_alarm_flag, exp_irq}
    localparam int NVEC = 13;
    localparam logic [7:0] VEC [NVEC] = '{
        8'b1010_0000, 8'b0110_0000, 8'b1100_0000, 8'b1110_0000,
        8'b0010_0000, 8'b1110_0011, 8'b1100_0010, 8'b1111_1011,
        8'b1111_0100, 8'b1110_0000, 8'b0010_0000, 8'b1111_0111,
        8'b0011_0100
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk32k_en = 1'b0;
    logic [2:0]  tick_sel = 3'd7;
    logic        tick_ie = 1'b0;
    logic        alarm_ie = 1'b0;
    logic        wake_en = 1'b0;
    logic [21:0] live_time = X_TIME;
    logic [23:0] live_date = X_DATE;
    logic [21:0] alarm_time = A_TIME;
    logic [23:0] alarm_date = A_DATE;
    logic        flag_wr = 1'b0;
    logic [1:0]  flag_wdata = 2'b00;
    logic        alarm_flag, tick_flag, irq, wake_req;
    int          total = 0;
    int          bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rtc_tick_alarm_irq u_dut (
        .clk(clk), .rst_n(rst_n), .clk32k_en(clk32k_en), .tick_sel(tick_sel),
        .tick_ie(tick_ie), .alarm_ie(alarm_ie), .wake_en(wake_en),
        .live_time(live_time), .live_date(live_date),
        .alarm_time(alarm_time), .alarm_date(alarm_date),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .alarm_flag(alarm_flag), .tick_flag(tick_flag), .irq(irq), .wake_req(wake_req)
    );

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        clk32k_en = 1'b0;
        flag_wr = 1'b0;
        flag_wdata = 2'b00;
        live_time = X_TIME;
        live_date = X_DATE;
        run(2);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state with all enables on
        tick_ie = 1'b1; alarm_ie = 1'b1; wake_en = 1'b1;
        run(1);
        do_reset();
        run(1);
        chk("R1 alarm_flag", alarm_flag, 1'b0);
        chk("R1 tick_flag", tick_flag, 1'b0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 wake_req", wake_req, 1'b0);

        // Alarm/flag vector table (R4 R5 R6 R7 R8); divider idle
        tick_ie = 1'b0; wake_en = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            live_time  = VEC[i][7] ? A_TIME : X_TIME;
            live_date  = VEC[i][6] ? A_DATE : X_DATE;
            alarm_ie   = VEC[i][5];
            flag_wr    = VEC[i][4];
            flag_wdata = VEC[i][3:2];
            run(1);
            chk($sformatf("R4/R5/R6/R7 vec%0d alarm_flag", i), alarm_flag, VEC[i][1]);
            chk($sformatf("R8 vec%0d irq", i), irq, VEC[i][0]);
            chk($sformatf("R11 vec%0d tick_flag", i), tick_flag, 1'b0);
        end
        flag_wr = 1'b0; flag_wdata = 2'b00;

        // R2 R3 R9: code 7, tick on enabled cycle 256, wake pulse
        alarm_ie = 1'b0; tick_ie = 1'b1; wake_en = 1'b1; tick_sel = 3'd7;
        do_reset();
        clk32k_en = 1'b1;
        run(255);
        chk("R2 code7 before tick", tick_flag, 1'b0);
        chk("R9 no wake before tick", wake_req, 1'b0);
        run(1);
        chk("R2 R3 code7 tick sets flag", tick_flag, 1'b1);
        chk("R9 wake pulse", wake_req, 1'b1);
        chk("R8 irq from tick", irq, 1'b1);
        clk32k_en = 1'b0;
        run(1);
        chk("R9 wake one cycle", wake_req, 1'b0);
        chk("R6 tick kept without write", tick_flag, 1'b1);
        flag_wr = 1'b1; flag_wdata = 2'b01;
        run(1);
        chk("R6 write 0 keeps tick", tick_flag, 1'b1);
        flag_wdata = 2'b10;
        run(1);
        chk("R6 write 1 clears tick", tick_flag, 1'b0);
        chk("R8 irq drops", irq, 1'b0);
        flag_wr = 1'b0; flag_wdata = 2'b00;

        // R3 R9: tick with tick_ie and wake_en off
        tick_ie = 1'b0; wake_en = 1'b0;
        do_reset();
        clk32k_en = 1'b1;
        run(256);
        chk("R3 disabled tick no flag", tick_flag, 1'b0);
        chk("R9 wake_en off no wake", wake_req, 1'b0);

        // R9: wake on tick irrespective of tick_ie
        wake_en = 1'b1;
        run(256);
        chk("R9 wake with tick_ie off", wake_req, 1'b1);
        wake_en = 1'b0;

        // R7: set and clear in the same cycle
        tick_ie = 1'b1;
        do_reset();
        clk32k_en = 1'b1;
        run(255);
        flag_wr = 1'b1; flag_wdata = 2'b10;
        run(1);
        chk("R7 tick set beats clear", tick_flag, 1'b1);
        flag_wr = 1'b0; flag_wdata = 2'b00;

        // R2 R11: code 3 with idle gap, 4096 enabled cycles
        tick_sel = 3'd3;
        do_reset();
        clk32k_en = 1'b1; run(100);
        clk32k_en = 1'b0; run(500);
        chk("R11 idle no tick", tick_flag, 1'b0);
        clk32k_en = 1'b1; run(3995);
        chk("R11 code3 before tick", tick_flag, 1'b0);
        run(1);
        chk("R2 R11 code3 tick", tick_flag, 1'b1);

        // R2: code 0, one second
        tick_sel = 3'd0;
        do_reset();
        clk32k_en = 1'b1;
        run(32767);
        chk("R2 code0 before tick", tick_flag, 1'b0);
        run(1);
        chk("R2 code0 tick", tick_flag, 1'b1);

        // R10: alarm set event wakes regardless of wake_en
        tick_ie = 1'b0; wake_en = 1'b0; alarm_ie = 1'b1;
        do_reset();
        live_time = A_TIME; live_date = A_DATE;
        run(1);
        chk("R10 alarm wake", wake_req, 1'b1);
        chk("R4 alarm flag", alarm_flag, 1'b1);
        run(1);
        chk("R10 alarm wake one cycle", wake_req, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule